// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block links two 8-bit buses, side A and side B, in both directions. Each direction owns one storage register with its own capture clock. The A-to-B register samples the A bus on every rising edge of its clock. The B-to-A register samples the B bus on every rising edge of its clock. Capture happens whatever the select and enable inputs are doing.

Each direction has a select input that picks what the driven bus carries. When the select is low, the bus carries live data from the opposite bus. When it is high, the bus carries the value held in that direction's register.

The two drive enables have opposite polarity. The B side drives while `en_ab_i` is high. The A side drives while `en_ba_ni` is low. No tri-state pins are used. Each side has separate input, output and per-bit output-enable vectors, and the pad or bus fabric outside resolves them.

When both sides drive in live mode, each output repeats what arrives at the other side. The two buses then keep their value without using either register.

Top module: `xcvr_reg_bridge`

## Requirements
- R1: An active-low asynchronous reset `rst_ni` clears both storage registers to 8'h00. Afterwards, both sides read 8'h00 when enabled with the stored source selected.
- R2: On every rising edge of `clk_ab_i`, the A-to-B register loads `a_i`, whatever the values of `en_ab_i`, `en_ba_ni`, `sel_ab_i` and `sel_ba_i`.
- R3: On every rising edge of `clk_ba_i`, the B-to-A register loads `b_i`, whatever the values of the enable and select inputs.
- R4: `b_oe_o` is all ones (8'hFF) while `en_ab_i` is 1, and all zeros while `en_ab_i` is 0.
- R5: `a_oe_o` is all ones while `en_ba_ni` is 0, and all zeros while `en_ba_ni` is 1.
- R6: While the B side is enabled, `b_o` equals `a_i` when `sel_ab_i` is 0 (live source), and equals the A-to-B register when `sel_ab_i` is 1 (stored source).
- R7: While the A side is enabled, `a_o` equals `b_i` when `sel_ba_i` is 0, and equals the B-to-A register when `sel_ba_i` is 1.
- R8: With `en_ab_i`=1, `en_ba_ni`=0 and both selects at 1, `a_o` shows the B-to-A register and `b_o` shows the A-to-B register at the same time.
- R9: With both sides enabled and both selects at 0, `a_o` equals `b_i` and `b_o` equals `a_i`, so each bus holds its own level through the other side.
- R10: A capture edge on one register clock leaves the other direction's register unchanged.
- R11: While a side is disabled, its data output is 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ab_i | input | 1 | Capture clock of the A-to-B register (rising edge) |
| clk_ba_i | input | 1 | Capture clock of the B-to-A register (rising edge) |
| rst_ni | input | 1 | Asynchronous reset, active low, clears both registers |
| en_ab_i | input | 1 | B side drive enable, active high |
| en_ba_ni | input | 1 | A side drive enable, active low |
| sel_ab_i | input | 1 | B side source: 0 live A bus, 1 stored A-to-B register |
| sel_ba_i | input | 1 | A side source: 0 live B bus, 1 stored B-to-A register |
| a_i | input | 8 | Resolved level of the A bus |
| b_i | input | 8 | Resolved level of the B bus |
| a_o | output | 8 | Value driven onto the A bus |
| a_oe_o | output | 8 | Per-bit drive enable for the A bus |
| b_o | output | 8 | Value driven onto the B bus |
| b_oe_o | output | 8 | Per-bit drive enable for the B bus |

## Verification
A wrong value in either storage register is invisible until that side is enabled with the stored source selected. From then on it appears on the data output with no added delay.

The bench therefore reads back every register after each capture pulse by switching to the stored source. It also reads back the opposite register after each pulse, which exposes a capture that leaked across from the other clock.

A wrong enable or source choice is purely combinational. It shows up on the outputs within the same settle window in which the control input changes. The bench sweeps all sixteen control combinations for this reason.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  typedef enum logic {
    SRC_LIVE   = 1'b0,
    SRC_STORED = 1'b1
  } src_e;
endpackage

// File: rtl/xcvr_capture_reg.sv
module xcvr_capture_reg #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= d_i;
  end
endmodule

// File: rtl/xcvr_drive_path.sv
module xcvr_drive_path
  import xcvr_pkg::*;
#(
  parameter int W          = 8,
  parameter bit ACTIVE_LOW = 1'b0
) (
  input  logic         en_i,
  input  logic         sel_i,
  input  logic [W-1:0] live_i,
  input  logic [W-1:0] stored_i,
  output logic [W-1:0] data_o,
  output logic [W-1:0] oe_o
);
  logic en_act;
  src_e src;

  generate
    if (ACTIVE_LOW) begin : g_en_low
      assign en_act = ~en_i;
    end else begin : g_en_high
      assign en_act = en_i;
    end
  endgenerate

  assign src = src_e'(sel_i);

  always_comb begin
    data_o = '0;
    if (en_act) begin
      unique case (src)
        SRC_LIVE:   data_o = live_i;
        SRC_STORED: data_o = stored_i;
        default:    data_o = '0;
      endcase
    end
  end

  // replicate the enable across every bit lane
  assign oe_o = {W{en_act}};
endmodule

// File: rtl/xcvr_reg_bridge.sv
module xcvr_reg_bridge #(
  parameter int W = 8
) (
  input  logic         clk_ab_i,
  input  logic         clk_ba_i,
  input  logic         rst_ni,
  input  logic         en_ab_i,
  input  logic         en_ba_ni,
  input  logic         sel_ab_i,
  input  logic         sel_ba_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] a_o,
  output logic [W-1:0] a_oe_o,
  output logic [W-1:0] b_o,
  output logic [W-1:0] b_oe_o
);
  logic [W-1:0] q_ab, q_ba;

  xcvr_capture_reg #(.W(W)) u_reg_ab (
    .clk_i(clk_ab_i), .rst_ni(rst_ni), .d_i(a_i), .q_o(q_ab)
  );
  xcvr_capture_reg #(.W(W)) u_reg_ba (
    .clk_i(clk_ba_i), .rst_ni(rst_ni), .d_i(b_i), .q_o(q_ba)
  );

  xcvr_drive_path #(.W(W), .ACTIVE_LOW(1'b0)) u_drv_b (
    .en_i(en_ab_i), .sel_i(sel_ab_i), .live_i(a_i), .stored_i(q_ab),
    .data_o(b_o), .oe_o(b_oe_o)
  );
  xcvr_drive_path #(.W(W), .ACTIVE_LOW(1'b1)) u_drv_a (
    .en_i(en_ba_ni), .sel_i(sel_ba_i), .live_i(b_i), .stored_i(q_ba),
    .data_o(a_o), .oe_o(a_oe_o)
  );

  // checker state: set once a capture edge has occurred since reset
  logic armed_ab, armed_ba;
  always_ff @(posedge clk_ab_i or negedge rst_ni) begin
    if (!rst_ni) armed_ab <= 1'b0;
    else         armed_ab <= 1'b1;
  end
  always_ff @(posedge clk_ba_i or negedge rst_ni) begin
    if (!rst_ni) armed_ba <= 1'b0;
    else         armed_ba <= 1'b1;
  end

  p_ab_stored_r2: assert property (@(posedge clk_ab_i) disable iff (!rst_ni)
    (armed_ab && en_ab_i && sel_ab_i) |-> (b_o == $past(a_i)));
  p_ba_stored_r3: assert property (@(posedge clk_ba_i) disable iff (!rst_ni)
    (armed_ba && !en_ba_ni && sel_ba_i) |-> (a_o == $past(b_i)));
  p_b_oe_r4: assert property (@(posedge clk_ab_i) disable iff (!rst_ni)
    (b_oe_o == {W{en_ab_i}}));
  p_a_oe_r5: assert property (@(posedge clk_ba_i) disable iff (!rst_ni)
    (a_oe_o == {W{~en_ba_ni}}));
  p_b_live_r6: assert property (@(posedge clk_ab_i) disable iff (!rst_ni)
    (en_ab_i && !sel_ab_i) |-> (b_o == a_i));
  p_a_live_r7: assert property (@(posedge clk_ba_i) disable iff (!rst_ni)
    (!en_ba_ni && !sel_ba_i) |-> (a_o == b_i));
  p_b_off_r11: assert property (@(posedge clk_ab_i) disable iff (!rst_ni)
    !en_ab_i |-> (b_o == '0));
  p_a_off_r11: assert property (@(posedge clk_ba_i) disable iff (!rst_ni)
    en_ba_ni |-> (a_o == '0));
endmodule

// File: tb/xcvr_reg_bridge_bench.sv
module xcvr_reg_bridge_bench;
  localparam int W = 8;

  logic clk = 1'b0;
  logic clk_ab = 1'b0, clk_ba = 1'b0, rst_n = 1'b0;
  logic en_ab = 1'b0, en_ba_n = 1'b1, sel_ab = 1'b0, sel_ba = 1'b0;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic [W-1:0] a_out, a_oe, b_out, b_oe;

  int checks = 0, errors = 0;
  logic [W-1:0] m_ab = '0, m_ba = '0;

  always #2.5 clk = ~clk;

  xcvr_reg_bridge #(.W(W)) u_xcvr_reg_bridge (
    .clk_ab_i(clk_ab), .clk_ba_i(clk_ba), .rst_ni(rst_n),
    .en_ab_i(en_ab), .en_ba_ni(en_ba_n), .sel_ab_i(sel_ab), .sel_ba_i(sel_ba),
    .a_i(a_in), .b_i(b_in), .a_o(a_out), .a_oe_o(a_oe), .b_o(b_out), .b_oe_o(b_oe)
  );

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pulse_ab();
    @(negedge clk); clk_ab = 1'b1; m_ab = a_in;
    @(negedge clk); clk_ab = 1'b0;
  endtask
  task automatic pulse_ba();
    @(negedge clk); clk_ba = 1'b1; m_ba = b_in;
    @(negedge clk); clk_ba = 1'b0;
  endtask

  task automatic check_all(string tag);
    logic [W-1:0] eb, ea;
    #1;
    eb = !en_ab ? '0 : (sel_ab ? m_ab : a_in);
    ea = en_ba_n ? '0 : (sel_ba ? m_ba : b_in);
    chk({tag, " R4 b_oe"}, b_oe, {W{en_ab}});
    chk({tag, " R5 a_oe"}, a_oe, {W{~en_ba_n}});
    chk({tag, en_ab ? " R6 b_o" : " R11 b_o"}, b_out, eb);
    chk({tag, !en_ba_n ? " R7 a_o" : " R11 a_o"}, a_out, ea);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: registers clear at reset
    en_ab = 1'b1; en_ba_n = 1'b0; sel_ab = 1'b1; sel_ba = 1'b1;
    #1;
    chk("R1 b_o after reset", b_out, 8'h00);
    chk("R1 a_o after reset", a_out, 8'h00);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2/R3: capture while both sides disabled, then read back
    en_ab = 1'b0; en_ba_n = 1'b1; sel_ab = 1'b0; sel_ba = 1'b0;
    a_in = 8'h3C; b_in = 8'hC3;
    pulse_ab(); pulse_ba();
    a_in = 8'h00; b_in = 8'hFF;
    en_ab = 1'b1; en_ba_n = 1'b0; sel_ab = 1'b1; sel_ba = 1'b1;
    #1;
    chk("R2 capture while disabled", b_out, 8'h3C);
    chk("R3 capture while disabled", a_out, 8'hC3);
    chk("R8 simultaneous stored b", b_out, m_ab);
    chk("R8 simultaneous stored a", a_out, m_ba);

    // R10: capture on one clock leaves the other register
    a_in = 8'h5A; b_in = 8'hA5;
    pulse_ab();
    #1;
    chk("R10 ba unchanged by clk_ab", a_out, 8'hC3);
    chk("R2 ab loaded", b_out, 8'h5A);
    pulse_ba();
    #1;
    chk("R10 ab unchanged by clk_ba", b_out, 8'h5A);
    chk("R3 ba loaded", a_out, 8'hA5);

    // R9: both live, each output repeats the far bus
    sel_ab = 1'b0; sel_ba = 1'b0; a_in = 8'h96; b_in = 8'h96;
    #1;
    chk("R9 b_o holds A", b_out, 8'h96);
    chk("R9 a_o holds B", a_out, 8'h96);

    // exhaustive control sweep with varied data and capture patterns
    for (int c = 0; c < 16; c++) begin
      for (int p = 0; p < 8; p++) begin
        @(negedge clk);
        {en_ab, en_ba_n, sel_ab, sel_ba} = 4'(c);
        a_in = 8'(p * 37 + c * 11 + 5);
        b_in = 8'(p * 91 + c * 7 + 200);
        if (p[0]) pulse_ab();
        if (p[1]) pulse_ba();
        a_in = ~a_in;
        b_in = 8'(b_in ^ 8'h5A);
        check_all("sweep R2 R3");
      end
    end

    // R1: mid-run asynchronous reset
    a_in = 8'h77; b_in = 8'h88;
    pulse_ab(); pulse_ba();
    #1 rst_n = 1'b0;
    #1;
    m_ab = '0; m_ba = '0;
    en_ab = 1'b1; en_ba_n = 1'b0; sel_ab = 1'b1; sel_ba = 1'b1;
    #1;
    chk("R1 mid-run reset b", b_out, 8'h00);
    chk("R1 mid-run reset a", a_out, 8'h00);
    rst_n = 1'b1;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule